// File: doc/BRIEF.md
# Strobe-Sampled General-Purpose I/O Port

This block is a bank of general-purpose digital lines (32 by default). Each line can be set on its own to drive its pad or to listen to it. The block keeps one register of sampled input values, and it takes a new snapshot of every input line on a chosen sampling event.

The sampling event can be either edge of the system clock, or either edge of an external application strobe. The strobe is brought into the clock domain through a two-stage synchroniser and then edge-detected. When a sampled input line changes value from one snapshot to the next, it sets a sticky per-line flag, provided its enable bit is set. Software clears a flag by writing 1 to it. A single interrupt output is high while any enabled flag is set.

Software reaches the configuration and state through a simple single-cycle register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `strobe_gpio_port`

## Requirements
- R1: After reset, every register reads 0. `pad_oe`, `pad_out` and `irq` are 0.
- R2: Address 0 holds the direction mask, where bit = 1 makes the line an output. `pad_oe` follows it from the edge that writes it. Address 1 holds the output data, which appears on `pad_out` from the edge that writes it.
- R3: Clock-rising sampling: address 5 = 0 selects this mode. The sampled-input register at address 2 loads `pad_in` on every rising clock edge, so it is readable one edge after the pads change.
- R4: Clock-falling sampling: address 5 bit1 = 1 and bit0 = 0 selects this mode. `pad_in` is captured on the falling clock edge and loaded at the following rising edge. A pad change that arrives after a falling edge is therefore not seen at the next rising edge.
- R5: Strobe sampling: address 5 bit0 = 1 selects this mode, and bit1 picks the falling (1) or rising (0) strobe edge. A selected strobe edge seen before rising edge k loads the sampled register at edge k+2. The unselected edge, and any cycle without a strobe edge, leave the register unchanged.
- R6: On a sampling event, a line that is an input, has its enable bit set (address 3), and whose sampled value differs from the previous sample sets its flag in the flag register at address 4.
- R7: Lines configured as outputs never set a flag, whatever their pads do.
- R8: Flags are sticky. Writing 1 to a bit of address 4 clears that bit, and writing 0 has no effect. If a flag is being set in the same cycle that it is being cleared, the set wins.
- R9: `irq` is high exactly when some flag is set and its enable bit is also set. Clearing an enable bit hides that flag without clearing it.
- R10: Address 5 reads back its two bits. Writes to address 2 are ignored. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Combinational read data |
| pad_in | input | W | Pad input values |
| pad_out | output | W | Pad output values |
| pad_oe | output | W | Pad output enables |
| strobe_in | input | 1 | External sampling strobe (asynchronous) |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land on the same flag bit in the same cycle: an input change that sets the flag, and a write-one clear of that flag. The bench provokes this on purpose. It changes a pad and writes a clear mask covering that line in one cycle, and it expects the flag to stay set while the other cleared bits drop. Random phases then mix pad changes, direction and enable rewrites, and clear masks in arbitrary cycles. Every cycle is compared against a bench model that applies the set before the clear.

// File: rtl/sgp_pkg.sv
`timescale 1ns/1ps
package sgp_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR   = 3'd0,
    A_DOUT  = 3'd1,
    A_DIN   = 3'd2,
    A_IEN   = 3'd3,
    A_IFLAG = 3'd4,
    A_CFG   = 3'd5
  } reg_addr_e;

  // bit1: falling edge select, bit0: strobe source select
  typedef struct packed {
    logic edge_fall;
    logic src_strobe;
  } samp_cfg_t;
endpackage

// File: rtl/sgp_regs.sv
`timescale 1ns/1ps
module sgp_regs import sgp_pkg::*; #(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      din,
  input  logic [W-1:0]      flags,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      ien,
  output logic [W-1:0]      w1c,
  output logic [W-1:0]      rdata,
  output samp_cfg_t         cfg
);
  localparam int CFG_PAD = W - $bits(samp_cfg_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir  <= '0;
      dout <= '0;
      ien  <= '0;
      cfg  <= '0;
    end else if (we) begin
      case (reg_addr_e'(addr))
        A_DIR:   dir  <= wdata;
        A_DOUT:  dout <= wdata;
        A_IEN:   ien  <= wdata;
        A_CFG:   cfg  <= samp_cfg_t'(wdata[1:0]);
        default: ;
      endcase
    end
  end

  assign w1c = (we && (reg_addr_e'(addr) == A_IFLAG)) ? wdata : '0;

  always_comb begin
    case (reg_addr_e'(addr))
      A_DIR:   rdata = dir;
      A_DOUT:  rdata = dout;
      A_DIN:   rdata = din;
      A_IEN:   rdata = ien;
      A_IFLAG: rdata = flags;
      A_CFG:   rdata = {{CFG_PAD{1'b0}}, cfg};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/sgp_sampler.sv
`timescale 1ns/1ps
module sgp_sampler import sgp_pkg::*; #(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  samp_cfg_t cfg,
  input  logic [W-1:0] pad_in,
  input  logic      strobe_in,
  output logic [W-1:0] din,
  output logic [W-1:0] new_sample,
  output logic      sample_evt
);
  localparam int SH_LEN = SYNC_STAGES + 1;

  logic [W-1:0]      neg_cap;
  logic [SH_LEN-1:0] stb_sh;
  logic              stb_rise, stb_fall;

  // capture of the pads on the falling clock edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_cap <= '0;
    else        neg_cap <= pad_in;
  end

  // synchroniser stages plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_sh <= '0;
    else        stb_sh <= {stb_sh[SH_LEN-2:0], strobe_in};
  end

  assign stb_rise = stb_sh[SYNC_STAGES-1] & ~stb_sh[SYNC_STAGES];
  assign stb_fall = ~stb_sh[SYNC_STAGES-1] & stb_sh[SYNC_STAGES];

  always_comb begin
    if (cfg.src_strobe) sample_evt = cfg.edge_fall ? stb_fall : stb_rise;
    else                sample_evt = 1'b1;
    new_sample = (!cfg.src_strobe && cfg.edge_fall) ? neg_cap : pad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          din <= '0;
    else if (sample_evt) din <= new_sample;
  end
endmodule

// File: rtl/sgp_irq.sv
`timescale 1ns/1ps
module sgp_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_evt,
  input  logic [W-1:0] din_old,
  input  logic [W-1:0] din_new,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] ien,
  input  logic [W-1:0] w1c,
  output logic [W-1:0] flags,
  output logic [W-1:0] set_mask,
  output logic         irq
);
  function automatic logic [W-1:0] change_mask(
    input logic [W-1:0] prev, input logic [W-1:0] cur,
    input logic [W-1:0] outs, input logic [W-1:0] enb);
    return (prev ^ cur) & ~outs & enb;
  endfunction

  // set has priority over a clear in the same cycle
  function automatic logic [W-1:0] next_flags(
    input logic [W-1:0] cur, input logic [W-1:0] clr, input logic [W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  assign set_mask = sample_evt ? change_mask(din_old, din_new, dir, ien) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= next_flags(flags, w1c, set_mask);
  end

  assign irq = |(flags & ien);
endmodule

// File: rtl/strobe_gpio_port.sv
`timescale 1ns/1ps
module strobe_gpio_port import sgp_pkg::*; #(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  input  logic              strobe_in,
  output logic              irq
);
  logic [W-1:0] dir_q, dout_q, ien_q, w1c_mask;
  logic [W-1:0] din_q, new_sample, flags_q, set_mask;
  logic         sample_evt;
  samp_cfg_t    cfg_q;

  sgp_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .din(din_q), .flags(flags_q), .dir(dir_q), .dout(dout_q), .ien(ien_q),
    .w1c(w1c_mask), .rdata(reg_rdata), .cfg(cfg_q)
  );

  sgp_sampler #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .pad_in(pad_in), .strobe_in(strobe_in),
    .din(din_q), .new_sample(new_sample), .sample_evt(sample_evt)
  );

  sgp_irq #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n), .sample_evt(sample_evt), .din_old(din_q),
    .din_new(new_sample), .dir(dir_q), .ien(ien_q), .w1c(w1c_mask),
    .flags(flags_q), .set_mask(set_mask), .irq(irq)
  );

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/sgp_checker.sv
`timescale 1ns/1ps
module sgp_checker import sgp_pkg::*; #(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [W-1:0]      reg_wdata,
  input logic [W-1:0]      pad_oe,
  input logic              irq,
  input logic [W-1:0]      dir,
  input logic [W-1:0]      ien,
  input logic [W-1:0]      flags,
  input logic [W-1:0]      set_mask,
  input logic [W-1:0]      din,
  input logic              sample_evt
);
  logic wr_dir, wr_flag;
  assign wr_dir  = reg_we && (reg_addr == A_DIR);
  assign wr_flag = reg_we && (reg_addr == A_IFLAG);

  assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pad_oe == $past(reg_wdata)));

  assert_din_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_evt |=> $stable(din));

  assert_no_flag_on_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & $past(dir)) == '0));

  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag |=> ((flags & $past(reg_wdata) & ~$past(set_mask)) == '0));

  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_flag && (set_mask == '0)) |=> $stable(flags));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (($past(set_mask) != '0) || !$stable(ien)));
endmodule

bind strobe_gpio_port sgp_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pad_oe(pad_oe), .irq(irq), .dir(dir_q), .ien(ien_q),
  .flags(flags_q), .set_mask(set_mask), .din(din_q), .sample_evt(sample_evt)
);

// File: tb/strobe_gpio_port_tb.sv
`timescale 1ns/1ps
module strobe_gpio_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        strobe_in = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_dir = '0, m_dout = '0, m_ien = '0, m_flag = '0, m_din = '0;
  logic [1:0]  m_cfg = '0;

  always #2.5 clk = ~clk;

  strobe_gpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .strobe_in(strobe_in), .irq(irq)
  );

  function automatic logic [31:0] exp_set(logic [31:0] prev, logic [31:0] cur,
                                          logic [31:0] outs, logic [31:0] enb);
    logic [31:0] diff = prev ^ cur;
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) r[b] = diff[b] && !outs[b] && enb[b];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.2;
    v = reg_rdata;
  endtask

  task automatic model_edge(input bit we, input logic [2:0] a, input logic [31:0] d,
                            input bit evt, input logic [31:0] smp);
    logic [31:0] set_v = evt ? exp_set(m_din, smp, m_dir, m_ien) : '0;
    logic [31:0] clr_v = (we && a == 3'd4) ? d : '0;
    for (int b = 0; b < 32; b++) m_flag[b] = set_v[b] ? 1'b1 : (clr_v[b] ? 1'b0 : m_flag[b]);
    if (evt) m_din = smp;
    if (we) begin
      case (a)
        3'd0: m_dir = d;
        3'd1: m_dout = d;
        3'd3: m_ien = d;
        3'd5: m_cfg = d[1:0];
        default: ;
      endcase
    end
  endtask

  task automatic tick(input bit we, input logic [2:0] a, input logic [31:0] d, input bit evt);
    logic [31:0] smp = pad_in;
    reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_we = 1'b0;
    model_edge(we, a, d, evt, smp);
  endtask

  task automatic tk(input bit we, input logic [2:0] a, input logic [31:0] d);
    tick(we, a, d, !m_cfg[0]);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    rd(3'd4, v); chk({tag, " flags"}, v, m_flag);
    rd(3'd2, v); chk({tag, " din"}, v, m_din);
    chk({tag, " irq R9"}, {31'd0, irq}, {31'd0, |(m_flag & m_ien)});
    chk({tag, " pad_oe R2"}, pad_oe, m_dir);
    chk({tag, " pad_out R2"}, pad_out, m_dout);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v); chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset irq", {31'd0, irq}, 32'h0);
    chk("R1 reset pad_oe", pad_oe, 32'h0);
    chk("R1 reset pad_out", pad_out, 32'h0);

    // R10: config readback, read-only din, unused addresses
    tk(1, 3'd5, 32'h3);
    rd(3'd5, v); chk("R10 cfg readback", v, 32'h3);
    tk(1, 3'd5, 32'hFFFF_FFFC);
    rd(3'd5, v); chk("R10 cfg cleared", v, 32'h0);
    pad_in = 32'h0000_00F0;
    tk(0, 3'd0, 0);
    tk(1, 3'd2, 32'hDEAD_BEEF);
    rd(3'd2, v); chk("R10 din write ignored", v, m_din);
    rd(3'd6, v); chk("R10 addr6 reads 0", v, 32'h0);
    rd(3'd7, v); chk("R10 addr7 reads 0", v, 32'h0);

    // R2: direction and output data
    tk(1, 3'd0, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe, 32'hA5A5_0F0F);
    tk(1, 3'd1, 32'h1234_5678);
    chk("R2 pad_out", pad_out, 32'h1234_5678);
    tk(1, 3'd0, 32'h0);

    // R3: clock rising sampling
    pad_in = 32'hCAFE_0001; tk(0, 3'd0, 0);
    rd(3'd2, v); chk("R3 din after one edge", v, 32'hCAFE_0001);
    pad_in = 32'h0F0F_F0F0; tk(0, 3'd0, 0);
    check_all("R3");

    // R6 / R9: flags on enabled inputs
    tk(1, 3'd3, 32'hFFFF_0000);
    pad_in = ~pad_in; tk(0, 3'd0, 0);
    check_all("R6");
    chk("R6 upper flags", m_flag, 32'hFFFF_0000);
    tk(1, 3'd3, 32'h0);
    check_all("R9 masked");
    chk("R9 irq low when disabled", {31'd0, irq}, 32'h0);
    tk(1, 3'd3, 32'hFFFF_FFFF);
    check_all("R9 re-enabled");

    // R8: write 0, write 1, set versus clear in one cycle
    tk(1, 3'd4, 32'h0);
    check_all("R8 write zero");
    pad_in = pad_in ^ 32'h0000_0001;
    tk(1, 3'd4, 32'h0001_0001);
    check_all("R8 set wins");
    rd(3'd4, v); chk("R8 bit0 kept, bit16 cleared", v & 32'h0001_0001, 32'h0000_0001);
    tk(1, 3'd4, 32'hFFFF_FFFF);
    check_all("R8 clear all");

    // R7: outputs never flag
    tk(1, 3'd0, 32'hFFFF_FFFF);
    pad_in = ~pad_in; tk(0, 3'd0, 0);
    pad_in = $urandom; tk(0, 3'd0, 0);
    check_all("R7");
    chk("R7 no flags", m_flag, 32'h0);
    tk(1, 3'd0, 32'h0);
    tk(1, 3'd4, 32'hFFFF_FFFF);

    // R4: falling clock edge capture
    tk(1, 3'd5, 32'h2);
    pad_in = 32'h1111_2222; tk(0, 3'd0, 0); tk(0, 3'd0, 0);
    check_all("R4 settled");
    #2;
    pad_in = 32'h3333_4444;
    @(posedge clk); #1;
    model_edge(0, 3'd0, 0, 1, m_din);
    rd(3'd2, v); chk("R4 late change not seen", v, 32'h1111_2222);
    tk(0, 3'd0, 0);
    rd(3'd2, v); chk("R4 seen next edge", v, 32'h3333_4444);
    check_all("R4");

    // R5: strobe rising
    tk(1, 3'd5, 32'h1);
    pad_in = 32'h5555_AAAA;
    tk(0, 3'd0, 0); tk(0, 3'd0, 0); tk(0, 3'd0, 0);
    check_all("R5 no strobe");
    strobe_in = 1'b1;
    tick(0, 3'd0, 0, 0); tick(0, 3'd0, 0, 0);
    rd(3'd2, v); chk("R5 not yet sampled", v, m_din);
    tick(0, 3'd0, 0, 1);
    rd(3'd2, v); chk("R5 sampled on rise", v, 32'h5555_AAAA);
    check_all("R5 rise");
    pad_in = 32'h0000_FFFF;
    strobe_in = 1'b0;
    tick(0, 3'd0, 0, 0); tick(0, 3'd0, 0, 0); tick(0, 3'd0, 0, 0);
    check_all("R5 fall ignored");

    // R5: strobe falling
    tk(1, 3'd5, 32'h3);
    strobe_in = 1'b1;
    tick(0, 3'd0, 0, 0); tick(0, 3'd0, 0, 0); tick(0, 3'd0, 0, 0);
    check_all("R5 rise ignored");
    strobe_in = 1'b0;
    tick(0, 3'd0, 0, 0); tick(0, 3'd0, 0, 0); tick(0, 3'd0, 0, 1);
    rd(3'd2, v); chk("R5 sampled on fall", v, 32'h0000_FFFF);
    check_all("R5 fall");

    // random mix in clock-rising mode
    tk(1, 3'd5, 32'h0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      if (r[0]) pad_in = $urandom;
      case (r[3:1])
        3'd0: tk(1, 3'd0, $urandom & $urandom);
        3'd1: tk(1, 3'd3, $urandom);
        3'd2, 3'd3: tk(1, 3'd4, $urandom);
        3'd4: tk(1, 3'd1, $urandom);
        default: tk(0, 3'd0, 0);
      endcase
      check_all("R6 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule